// File: doc/BRIEF.md
# DisplayPort AUX Request Engine

This block assembles a single DisplayPort AUX request, transmits it, and captures the reply. A host uses a small register window to set up a transfer. It loads the request header and any write payload into a 32-entry byte buffer through one data register, then writes a start command that includes the number of bytes to send. After an optional start delay, the engine sends the buffer contents in order over a byte stream with valid/ready handshaking and a last marker.

Once the final request byte has been accepted, the engine listens on a byte-wide receive stream. Each accepted reply byte is written into the same buffer, starting at entry 0, so the acknowledge byte comes first. The engine also accumulates per-byte receive error flags. A transfer ends in one of two ways: the sender marks the final reply byte, or the line stays idle for too long. When the transfer ends, the engine raises done and reports the reply length, any timeout, and the error flags in a status word. The host then reads the reply back through the data register and writes the acknowledge bit to clear done.

Top module: `aux_xact_engine`

## Requirements
- R1: The register window sits at byte offsets 0x00 (control), 0x04 (start control), 0x0C (interrupt), 0x10 (status) and 0x18 (data). The control register reads back as written. Start control reads back its 4-bit delay in bits 7:4 and its 5-bit send count in bits 20:16, and bit 0 always reads as 0.
- R2: A data-register write with bit 31 set loads the buffer pointer from bits 20:16. A write with bit 0 clear stores bits 15:8 at the pointer and then advances the pointer. A write with bit 0 set stores nothing. Each data read returns the byte at the pointer in bits 15:8 and the pointer in bits 20:16, then advances the pointer.
- R3: A transfer starts only when all of these hold: start control is written with bit 0 set, the send count is nonzero, control bit 0 (enable) is set, and the engine is idle. A start-control write made during a transfer is ignored completely.
- R4: The engine sends buffer entries 0 through count-1 in order. It holds each byte stable until ready is seen, and raises the last flag only with the final byte.
- R5: A start delay of D makes the first byte appear D×DELAY_UNIT cycles after the start write. With D=0, the first byte appears at once.
- R6: Reply bytes are stored from buffer entry 0 onward. When a byte carrying rx_last is accepted, the engine sets status bit 0, interrupt bit 0 and `irq`, and writes the received byte count into status bits 28:24.
- R7: Status bit 1 (pending) is high from the start until done. Status bits 6:4 hold the engine phase: 0 idle, 1 delay, 2 send, 3 awaiting reply, 4 receiving. After reset, status reads 0.
- R8: If TIMEOUT_CYC cycles pass with no reply byte, counted from the last sent byte or from the latest reply byte, the engine sets status bit 7 and done and forces the reply count to 0. It does not do this earlier.
- R9: Reply bytes beyond REPLY_MAX are discarded without touching the buffer. They set status bit 8, and the count saturates at REPLY_MAX.
- R10: rx_err[11:0] is accumulated with each accepted reply byte into status bits 8, 9, 10, 11, 12, 14, 17, 18, 19, 20, 22 and 23, in index order.
- R11: Writing 1 to interrupt bit 1 clears done. A new start clears done, timeout, the error flags and the reply count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data register reads advance the pointer) |
| reg_addr | input | 8 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tx_data | output | 8 | Request byte |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final request byte |
| rx_data | input | 8 | Reply byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_last | input | 1 | Final reply byte |
| rx_err | input | 12 | Receive error flags for this byte |
| irq | output | 1 | Done indication |

## Verification
The bench builds the engine with TIMEOUT_CYC set to 40 instead of the default 400. This puts the reply timeout, and the check that it does not fire early, within a few dozen cycles. REPLY_MAX stays at 20 and DELAY_UNIT stays at 16, so an overflowing reply of 22 bytes is still short. The largest start delay, 15 units or 240 cycles, can also be measured exactly against a count computed in the bench.

// File: rtl/aux_xact_engine.sv
module aux_xact_engine #(
  parameter int REPLY_MAX   = 20,
  parameter int TIMEOUT_CYC = 400,
  parameter int DELAY_UNIT  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_last,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_last,
  input  logic [11:0] rx_err,
  output logic        irq
);

  localparam int PW    = 5;
  localparam int DEPTH = 1 << PW;
  localparam int DW    = $clog2(15 * DELAY_UNIT + 1);
  localparam int TW    = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] OFS_CTL = 8'h00;
  localparam logic [7:0] OFS_SWC = 8'h04;
  localparam logic [7:0] OFS_INT = 8'h0C;
  localparam logic [7:0] OFS_STA = 8'h10;
  localparam logic [7:0] OFS_DAT = 8'h18;
  localparam int ERR_POS [12] = '{8, 9, 10, 11, 12, 14, 17, 18, 19, 20, 22, 23};

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_DLY = 3'd1, S_SEND = 3'd2, S_WAIT = 3'd3, S_RECV = 3'd4
  } st_t;

  st_t            st_q;
  logic [31:0]    ctl_q;
  logic [3:0]     delay_q;
  logic [PW-1:0]  count_q;
  logic [PW-1:0]  ptr_q, tptr_q, rcnt_q;
  logic [DW-1:0]  dcnt_q;
  logic [TW-1:0]  tcnt_q;
  logic           done_q, to_q;
  logic [11:0]    err_q;
  logic [7:0]     buf_q [DEPTH];
  logic [31:0]    sta;

  logic wr_swc, wr_dat, rd_dat, wr_int, go, busy, rx_take, rx_store;
  logic [PW-1:0] dat_ptr;

  assign wr_swc   = reg_wr && reg_addr == OFS_SWC;
  assign wr_dat   = reg_wr && reg_addr == OFS_DAT;
  assign wr_int   = reg_wr && reg_addr == OFS_INT;
  assign rd_dat   = reg_rd && reg_addr == OFS_DAT;
  assign busy     = st_q != S_IDLE;
  assign go       = wr_swc && reg_wdata[0] && reg_wdata[20:16] != 5'd0 && ctl_q[0] && !busy;
  assign dat_ptr  = reg_wdata[31] ? reg_wdata[20:16] : ptr_q;
  assign rx_take  = (st_q == S_WAIT || st_q == S_RECV) && rx_valid;
  assign rx_store = rx_take && int'(rcnt_q) < REPLY_MAX;

  assign tx_valid = st_q == S_SEND;
  assign tx_data  = buf_q[tptr_q];
  assign tx_last  = tx_valid && tptr_q == count_q - 5'd1;
  assign irq      = done_q;

  always_ff @(posedge clk) begin
    if (rx_store)
      buf_q[rcnt_q] <= rx_data;
    else if (wr_dat && !reg_wdata[0])
      buf_q[dat_ptr] <= reg_wdata[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_dat) begin
      if (!reg_wdata[0])     ptr_q <= dat_ptr + 5'd1;
      else if (reg_wdata[31]) ptr_q <= reg_wdata[20:16];
    end else if (rd_dat) begin
      ptr_q <= ptr_q + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ctl_q   <= '0;
      delay_q <= '0;
      count_q <= '0;
      tptr_q  <= '0;
      rcnt_q  <= '0;
      dcnt_q  <= '0;
      tcnt_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTL) ctl_q <= reg_wdata;
      if (wr_int && reg_wdata[1]) done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (wr_swc) begin
            delay_q <= reg_wdata[7:4];
            count_q <= reg_wdata[20:16];
          end
          if (go) begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            err_q  <= '0;
            rcnt_q <= '0;
            tptr_q <= '0;
            dcnt_q <= DW'(int'(reg_wdata[7:4]) * DELAY_UNIT - 1);
            st_q   <= (reg_wdata[7:4] == 4'd0) ? S_SEND : S_DLY;
          end
        end
        S_DLY: begin
          if (dcnt_q == '0) st_q <= S_SEND;
          else              dcnt_q <= dcnt_q - 1'b1;
        end
        S_SEND: begin
          if (tx_ready) begin
            tptr_q <= tptr_q + 5'd1;
            if (tx_last) begin
              st_q   <= S_WAIT;
              tcnt_q <= '0;
            end
          end
        end
        S_WAIT, S_RECV: begin
          if (rx_take) begin
            tcnt_q <= '0;
            st_q   <= S_RECV;
            err_q  <= err_q | rx_err;
            if (rx_store) rcnt_q <= rcnt_q + 5'd1;
            else          err_q[0] <= 1'b1;
            if (rx_last) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end
          end else if (tcnt_q == TW'(TIMEOUT_CYC - 1)) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            to_q   <= 1'b1;
            rcnt_q <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    sta        = '0;
    sta[0]     = done_q;
    sta[1]     = busy;
    sta[6:4]   = st_q;
    sta[7]     = to_q;
    for (int k = 0; k < 12; k++) sta[ERR_POS[k]] = err_q[k];
    sta[28:24] = rcnt_q;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTL: reg_rdata = ctl_q;
      OFS_SWC: reg_rdata = {11'd0, count_q, 8'd0, delay_q, 4'd0};
      OFS_INT: reg_rdata = {31'd0, done_q};
      OFS_STA: reg_rdata = sta;
      OFS_DAT: reg_rdata = {11'd0, ptr_q, buf_q[ptr_q], 8'd0};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/aux_xact_engine_chk.sv
module aux_xact_engine_chk #(
  parameter int REPLY_MAX = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last,
  input logic [7:0] tx_data,
  input logic       busy,
  input logic       done_q,
  input logic       to_q,
  input logic [4:0] rcnt_q,
  input logic [4:0] count_q,
  input logic       wr_swc
);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4

  AST_BUSY_SWC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_swc |=> $stable(count_q)); // R3

  AST_DONE_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R7

  AST_REPLY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rcnt_q) <= REPLY_MAX); // R9

  AST_TIMEOUT_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> rcnt_q == 5'd0); // R8

endmodule

bind aux_xact_engine aux_xact_engine_chk #(.REPLY_MAX(REPLY_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .busy(busy), .done_q(done_q),
  .to_q(to_q), .rcnt_q(rcnt_q), .count_q(count_q), .wr_swc(wr_swc)
);

// File: tb/aux_xact_engine_tb_top.sv
`timescale 1ns/1ps
module aux_xact_engine_tb_top;

  localparam int TOUT = 40;
  localparam logic [7:0] A_CTL = 8'h00, A_SWC = 8'h04, A_INT = 8'h0C, A_STA = 8'h10, A_DAT = 8'h18;
  // {1'b0, reply_len[4:0], is_write, len[4:0], addr[15:0], cmd[3:0]}
  localparam logic [31:0] VEC [6] = '{
    {1'b0, 5'd1,  1'b1, 5'd1,  16'h0100, 4'h8},
    {1'b0, 5'd17, 1'b0, 5'd16, 16'h0000, 4'h9},
    {1'b0, 5'd1,  1'b1, 5'd0,  16'h0050, 4'h4},
    {1'b0, 5'd1,  1'b1, 5'd16, 16'h2003, 4'h8},
    {1'b0, 5'd3,  1'b0, 5'd2,  16'h0202, 4'h9},
    {1'b0, 5'd1,  1'b1, 5'd5,  16'h0040, 4'h0}
  };

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, irq;
  logic        tx_ready = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_valid = 0, rx_last = 0;
  logic [11:0] rx_err = 0;

  int nchk = 0, nfail = 0;
  logic [7:0] txb [40];
  logic [7:0] exp_b [32];

  always #10 clk = ~clk;

  aux_xact_engine #(.TIMEOUT_CYC(TOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_err(rx_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic collect_tx(input bit toggle, output int got);
    bit lst = 0;
    int cyc = 0;
    got = 0;
    while (!lst && cyc < 400) begin
      tx_ready = toggle ? cyc[0] : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        txb[got] = tx_data;
        lst = tx_last;
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    tx_ready = 0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit l, input logic [11:0] e);
    rx_valid = 1; rx_data = b; rx_last = l; rx_err = e;
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1..R11 actual=hung expected=complete");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    int got, n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state
    rd(A_STA, d);
    chk(d == 0, "R7 reset status", d, 0);
    chk(!tx_valid && !irq, "R7 reset outputs", {tx_valid, irq}, 0);

    // R1 readback
    wr(A_SWC, (5 << 16) | (3 << 4));
    rd(A_SWC, d);
    chk(d == ((5 << 16) | (3 << 4)), "R1 start-control readback", d, (5 << 16) | (3 << 4));
    wr(A_CTL, 32'h0000_0101);
    rd(A_CTL, d);
    chk(d == 32'h101, "R1 control readback", d, 32'h101);

    // R2 pointer behaviour
    wr(A_DAT, 32'h8000_0000 | (7 << 16) | (8'h5A << 8));
    wr(A_DAT, 8'h5B << 8);
    wr(A_DAT, 32'h8000_0001 | (7 << 16) | (8'hFF << 8));
    rd(A_DAT, d);
    chk(d[15:8] == 8'h5A && d[20:16] == 7, "R2 indexed byte and rw-set write stores nothing", d, 32'h0007_5A00);
    rd(A_DAT, d);
    chk(d[15:8] == 8'h5B && d[20:16] == 8, "R2 auto advance", d, 32'h0008_5B00);

    // R3 enable off
    wr(A_CTL, 0);
    wr(A_SWC, (3 << 16) | 1);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R3 start without enable", tx_valid, 0);
    rd(A_STA, d);
    chk(d[1] == 0, "R3 no pending without enable", d, 0);
    wr(A_CTL, 1);
    wr(A_SWC, 1);
    rd(A_STA, d);
    chk(d[1] == 0, "R3 zero count ignored", d, 0);

    // Vector table
    for (int i = 0; i < 6; i++) begin
      logic [3:0]  cmd;
      logic [15:0] adr;
      int len, nrep, cnt, dly, bad;
      bit isw;
      cmd = VEC[i][3:0]; adr = VEC[i][19:4]; len = int'(VEC[i][24:20]);
      isw = VEC[i][25]; nrep = int'(VEC[i][30:26]); dly = i % 3;
      exp_b[0] = {cmd, 4'h0}; exp_b[1] = adr[15:8]; exp_b[2] = adr[7:0];
      cnt = 3;
      if (len > 0) begin
        exp_b[3] = 8'(len - 1);
        cnt = 4;
        if (isw) begin
          for (int k = 0; k < len; k++) exp_b[4 + k] = 8'(8'h30 + k + i * 7);
          cnt += len;
        end
      end
      wr(A_DAT, 32'h8000_0000 | (32'(exp_b[0]) << 8));
      for (int k = 1; k < cnt; k++) wr(A_DAT, 32'(exp_b[k]) << 8);
      wr(A_INT, 2);
      wr(A_SWC, (cnt << 16) | (dly << 4) | 1);
      n = 0;
      while (!tx_valid && n < 100) begin @(negedge clk); n++; end
      chk(n == dly * 16, "R5 start delay", n, dly * 16);
      collect_tx(i[0], got);
      chk(got == cnt, "R4 byte count with last flag", got, cnt);
      bad = 0;
      for (int k = 0; k < cnt; k++) if (txb[k] != exp_b[k]) bad++;
      chk(bad == 0, "R4 request bytes in order", bad, 0);
      for (int k = 0; k < nrep; k++)
        send_rx(k == 0 ? 8'h00 : 8'(8'hA0 + k + i), k == nrep - 1, 12'd0);
      rd(A_STA, d);
      chk(d == (32'(nrep) << 24 | 1), "R6 status after reply", d, 32'(nrep) << 24 | 1);
      chk(irq == 1, "R6 irq", irq, 1);
      wr(A_DAT, 32'h8000_0001);
      bad = 0;
      for (int k = 0; k < nrep; k++) begin
        rd(A_DAT, d);
        if (d[15:8] != (k == 0 ? 8'h00 : 8'(8'hA0 + k + i))) bad++;
      end
      chk(bad == 0, "R6 reply readback ack first", bad, 0);
      wr(A_INT, 2);
      rd(A_INT, d);
      chk(d[0] == 0, "R11 ack clears done", d, 0);
    end

    // R7 pending, R3 busy start ignored, R8 timeout
    wr(A_SWC, (3 << 16) | (15 << 4) | 1);
    rd(A_STA, d);
    chk(d[1] == 1 && d[6:4] == 1, "R7 pending in delay phase", d, 32'h12);
    wr(A_SWC, (10 << 16) | 1);
    rd(A_SWC, d);
    chk(d == ((3 << 16) | (15 << 4)), "R3 busy write ignored", d, (3 << 16) | (15 << 4));
    collect_tx(0, got);
    chk(got == 3, "R3 original count sent", got, 3);
    repeat (30) @(negedge clk);
    rd(A_STA, d);
    chk(d[0] == 0 && d[7] == 0 && d[6:4] == 3, "R8 no early timeout", d, 32'h32);
    repeat (20) @(negedge clk);
    rd(A_STA, d);
    chk(d == 32'h81, "R8 timeout flag done zero count", d, 32'h81);

    // R9 overflow
    wr(A_DAT, 32'h8000_0000 | (20 << 16) | (8'h11 << 8));
    wr(A_SWC, (3 << 16) | 1);
    collect_tx(0, got);
    for (int k = 0; k < 22; k++) send_rx(8'(8'hC0 + k), k == 21, 12'd0);
    rd(A_STA, d);
    chk(d == (32'd20 << 24 | 32'h101), "R9 overflow flag and saturated count", d, 32'd20 << 24 | 32'h101);
    wr(A_DAT, 32'h8000_0001 | (19 << 16));
    rd(A_DAT, d);
    chk(d[15:8] == 8'hD3, "R9 last kept byte", d[15:8], 8'hD3);
    rd(A_DAT, d);
    chk(d[15:8] == 8'h11, "R9 excess discarded", d[15:8], 8'h11);

    // R10 error mapping
    wr(A_SWC, (3 << 16) | 1);
    collect_tx(0, got);
    send_rx(8'h00, 0, 12'h002);
    send_rx(8'h55, 1, 12'h800);
    rd(A_STA, d);
    chk(d == (32'd2 << 24 | (1 << 23) | (1 << 9) | 1), "R10 error bits", d, 32'd2 << 24 | (1 << 23) | (1 << 9) | 1);

    // R11 start clears previous results
    wr(A_SWC, (3 << 16) | (1 << 4) | 1);
    rd(A_STA, d);
    chk(d == 32'h12, "R11 start clears status", d, 32'h12);
    collect_tx(0, got);
    send_rx(8'h00, 1, 12'd0);
    rd(A_STA, d);
    chk(d == (32'd1 << 24 | 1), "R10 errors cleared on next transfer", d, 32'd1 << 24 | 1);

    finish_up();
  end

endmodule